// File: doc/BRIEF.md
# LCD Panel Timing Generator

This block produces the raster timing for a parallel RGB LCD panel. Software programs the horizontal geometry in units of eight dots and the vertical geometry in lines through a small write-only register port. While running, the block walks a dot position through each frame on every cycle where the dot enable is high. From that position it drives horizontal sync, vertical sync, display enable and the pixel coordinates of the active area.

Each sync and enable output has its own programmable polarity. Frames can either repeat without pause or run one at a time, each started by a trigger write. A one-cycle frame-end pulse marks every completed frame, and an interrupt line follows a sticky frame-end status when enabled. A run bit controls a power status: it reads 3 while timing is running and 0 when stopped.

Timing values pass into a shadow copy only when a frame begins. A geometry change made in the middle of a frame therefore never produces a cut-short line or frame.

Top module: `lcd_timing_gen`

## Requirements
- R1: After reset hsync, vsync, de, px_x, px_y, frame_end, irq and pwr_state are all 0.
- R2: A write to address 0 with bit 0 set gives pwr_state 0 after the write edge, 1 after the next edge, and 3 after the following edge that has dot_en high. A write with bit 0 clear keeps 3 for one more edge, then gives 0 and stops all timing.
- R3: Address 1 holds the display width in units at [31:16] and the line total in units at [15:0]. One unit is 8 dots. The raw display enable is high while the unit index is below the display width and the line index is below the display height.
- R4: Address 2 holds the hsync width in units at [31:16] and the start unit at [15:0]. Raw hsync is high for unit indices from start up to start+width-1.
- R5: Address 3 holds the display height at [31:16] and the total line count at [15:0]. Address 4 holds the vsync width in lines at [31:16] and the start line at [15:0]. Raw vsync is high for lines from start up to start+width-1. px_y is the line index during display.
- R6: Address 5 sets the output polarities. Bit 28 set makes vsync active low, bit 27 set makes hsync active low, and bit 24 set inverts de. When stopped or idle, each output rests at its inactive level.
- R7: With address 0 bit 1 clear (continuous mode), frames follow one another with no gap.
- R8: With address 0 bit 1 set (one-shot mode), the block idles at power 3. Each write to address 6 with bit 0 set runs exactly one frame. A write to address 6 with bit 0 clear has no effect.
- R9: frame_end is high for exactly one cycle, the cycle after the last dot of each frame.
- R10: Address 7 bit 10 enables the frame-end status. When enabled, the status is set at each frame end and drives irq. Any write to address 7 clears it at the write edge.
- R11: Timing values written during a frame take effect only from the next frame start.
- R12: px_x (unit*8+dot) and px_y are 0 whenever the raw display enable is low.
- R13: While dot_en is low, the dot position, px_x and px_y hold still.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| dot_en | input | 1 | Dot advance enable |
| reg_we | input | 1 | Register write strobe |
| reg_addr | input | 3 | Register address |
| reg_wdata | input | 32 | Register write data |
| hsync | output | 1 | Horizontal sync (polarity applied) |
| vsync | output | 1 | Vertical sync (polarity applied) |
| de | output | 1 | Display enable (polarity applied) |
| px_x | output | HU_W+3 (13) | Pixel column during display, else 0 |
| px_y | output | LN_W (11) | Pixel row during display, else 0 |
| frame_end | output | 1 | One-cycle frame-end pulse |
| irq | output | 1 | Frame-end status |
| pwr_state | output | 2 | Power status: 0 off, 1 rising, 3 on |

## Verification
Register writes act at their write edge. pwr_state moves one edge after the run bit changes. The first dot of a frame appears two edges after a start write, or one edge after a trigger. frame_end appears one cycle after the last dot, and the sync, enable and pixel outputs follow the dot position within the same cycle. A reference model in the bench advances on every rising edge and pushes the expected output set into a queue just after that edge. A monitor pops and compares one entry on each falling edge, so every output is judged exactly in the cycle it is due. Directed checks add frame counts in both refresh modes, the shadow-load window, freezes under a low dot enable, and idle polarities.

// File: rtl/lcd_tg_pkg.sv
`timescale 1ns/1ps
package lcd_tg_pkg;
    localparam int FW     = 16;
    localparam int ADDR_W = 3;

    localparam logic [ADDR_W-1:0] A_CTRL = 3'd0;
    localparam logic [ADDR_W-1:0] A_HTIM = 3'd1;
    localparam logic [ADDR_W-1:0] A_HSYN = 3'd2;
    localparam logic [ADDR_W-1:0] A_VTIM = 3'd3;
    localparam logic [ADDR_W-1:0] A_VSYN = 3'd4;
    localparam logic [ADDR_W-1:0] A_POL  = 3'd5;
    localparam logic [ADDR_W-1:0] A_TRIG = 3'd6;
    localparam logic [ADDR_W-1:0] A_INT  = 3'd7;

    localparam int POL_V_BIT  = 28;
    localparam int POL_H_BIT  = 27;
    localparam int POL_DE_BIT = 24;
    localparam int FE_EN_BIT  = 10;

    localparam logic [1:0] PWR_OFF = 2'd0;
    localparam logic [1:0] PWR_UP  = 2'd1;
    localparam logic [1:0] PWR_ON  = 2'd3;

    typedef struct packed {
        logic [FW-1:0] htot;
        logic [FW-1:0] hdisp;
        logic [FW-1:0] hsp;
        logic [FW-1:0] hsw;
        logic [FW-1:0] vtot;
        logic [FW-1:0] vdisp;
        logic [FW-1:0] vsp;
        logic [FW-1:0] vsw;
    } timing_t;

    typedef struct packed {
        logic    run;
        logic    oneshot;
        logic    pol_v;
        logic    pol_h;
        logic    pol_de;
        logic    fe_en;
        timing_t tm;
    } cfg_t;
endpackage

// File: rtl/lcd_tg_regs.sv
`timescale 1ns/1ps
module lcd_tg_regs
    import lcd_tg_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [31:0]       wdata,
    output cfg_t              cfg,
    output logic              trig_wr,
    output logic              int_wr
);
    cfg_t r_d, r_q;

    always_comb begin
        r_d = r_q;
        if (we) begin
            unique case (addr)
                A_CTRL: begin
                    r_d.run     = wdata[0];
                    r_d.oneshot = wdata[1];
                end
                A_HTIM: begin
                    r_d.tm.hdisp = wdata[31:16];
                    r_d.tm.htot  = wdata[15:0];
                end
                A_HSYN: begin
                    r_d.tm.hsw = wdata[31:16];
                    r_d.tm.hsp = wdata[15:0];
                end
                A_VTIM: begin
                    r_d.tm.vdisp = wdata[31:16];
                    r_d.tm.vtot  = wdata[15:0];
                end
                A_VSYN: begin
                    r_d.tm.vsw = wdata[31:16];
                    r_d.tm.vsp = wdata[15:0];
                end
                A_POL: begin
                    r_d.pol_v  = wdata[POL_V_BIT];
                    r_d.pol_h  = wdata[POL_H_BIT];
                    r_d.pol_de = wdata[POL_DE_BIT];
                end
                A_INT:   r_d.fe_en = wdata[FE_EN_BIT];
                default: ;
            endcase
        end
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) r_q <= '0;
        else        r_q <= r_d;
    end

    assign cfg     = r_q;
    assign trig_wr = we && (addr == A_TRIG) && wdata[0];
    assign int_wr  = we && (addr == A_INT);
endmodule

// File: rtl/lcd_tg_seq.sv
`timescale 1ns/1ps
module lcd_tg_seq
    import lcd_tg_pkg::*;
#(
    parameter int PIX_PER_UNIT = 8,
    parameter int HU_W         = 10,
    parameter int LN_W         = 11,
    localparam int SUB_W       = $clog2(PIX_PER_UNIT)
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             dot_en,
    input  cfg_t             cfg,
    input  logic             trig_wr,
    input  logic             int_wr,
    output logic             busy,
    output logic [1:0]       pwr,
    output logic [SUB_W-1:0] sub,
    output logic [HU_W-1:0]  hu,
    output logic [LN_W-1:0]  ln,
    output timing_t          sh,
    output logic             frame_end,
    output logic             irq
);
    typedef struct packed {
        logic [1:0]       pwr;
        logic             busy;
        logic             trig;
        logic             fe;
        logic             stat;
        logic [SUB_W-1:0] sub;
        logic [HU_W-1:0]  hu;
        logic [LN_W-1:0]  ln;
        timing_t          sh;
    } seq_t;

    seq_t s_d, s_q;
    logic unit_end, line_end, frame_last, go, start_req;

    assign unit_end   = (s_q.sub == SUB_W'(PIX_PER_UNIT - 1));
    assign line_end   = unit_end && (FW'(s_q.hu) == s_q.sh.htot - FW'(1));
    assign frame_last = line_end && (FW'(s_q.ln) == s_q.sh.vtot - FW'(1));
    assign go         = !cfg.oneshot || s_q.trig;

    always_comb begin
        s_d       = s_q;
        s_d.fe    = 1'b0;
        start_req = 1'b0;
        if (!cfg.run) begin
            s_d.pwr  = PWR_OFF;
            s_d.busy = 1'b0;
            s_d.trig = 1'b0;
            s_d.sub  = '0;
            s_d.hu   = '0;
            s_d.ln   = '0;
        end else if (s_q.pwr == PWR_OFF) begin
            s_d.pwr = PWR_UP;
        end else if (dot_en) begin
            if (s_q.pwr == PWR_UP) s_d.pwr = PWR_ON;
            if (s_q.busy) begin
                if (frame_last) begin
                    s_d.fe   = 1'b1;
                    s_d.busy = 1'b0;
                    s_d.sub  = '0;
                    s_d.hu   = '0;
                    s_d.ln   = '0;
                    if (cfg.fe_en) s_d.stat = 1'b1;
                    start_req = go;
                end else if (line_end) begin
                    s_d.sub = '0;
                    s_d.hu  = '0;
                    s_d.ln  = s_q.ln + LN_W'(1);
                end else if (unit_end) begin
                    s_d.sub = '0;
                    s_d.hu  = s_q.hu + HU_W'(1);
                end else begin
                    s_d.sub = s_q.sub + SUB_W'(1);
                end
            end else begin
                start_req = go;
            end
            if (start_req) begin
                s_d.busy = 1'b1;
                s_d.trig = 1'b0;
                s_d.sh   = cfg.tm;
                s_d.sub  = '0;
                s_d.hu   = '0;
                s_d.ln   = '0;
            end
        end
        if (trig_wr && cfg.run) s_d.trig = 1'b1;
        if (int_wr)             s_d.stat = 1'b0;
    end

    always_ff @(posedge clk or negedge rst_n) begin
        if (!rst_n) s_q <= '0;
        else        s_q <= s_d;
    end

    assign busy      = s_q.busy;
    assign pwr       = s_q.pwr;
    assign sub       = s_q.sub;
    assign hu        = s_q.hu;
    assign ln        = s_q.ln;
    assign sh        = s_q.sh;
    assign frame_end = s_q.fe;
    assign irq       = s_q.stat;

    p_pwr_code_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.pwr != 2'd2);
    p_busy_powered_r2: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.busy |-> (s_q.pwr == PWR_ON));
    p_fe_single_r9: assert property (@(posedge clk) disable iff (!rst_n)
        s_q.fe |=> !s_q.fe);
    p_irq_clear_r10: assert property (@(posedge clk) disable iff (!rst_n)
        int_wr |=> !s_q.stat);
    p_freeze_r13: assert property (@(posedge clk) disable iff (!rst_n)
        (!dot_en && cfg.run && s_q.busy) |=> ($stable(s_q.sub) && $stable(s_q.hu) && $stable(s_q.ln)));
endmodule

// File: rtl/lcd_timing_gen.sv
`timescale 1ns/1ps
module lcd_timing_gen
    import lcd_tg_pkg::*;
#(
    parameter int PIX_PER_UNIT = 8,
    parameter int HU_W         = 10,
    parameter int LN_W         = 11,
    localparam int SUB_W       = $clog2(PIX_PER_UNIT),
    localparam int X_W         = HU_W + SUB_W
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              dot_en,
    input  logic              reg_we,
    input  logic [ADDR_W-1:0] reg_addr,
    input  logic [31:0]       reg_wdata,
    output logic              hsync,
    output logic              vsync,
    output logic              de,
    output logic [X_W-1:0]    px_x,
    output logic [LN_W-1:0]   px_y,
    output logic              frame_end,
    output logic              irq,
    output logic [1:0]        pwr_state
);
    cfg_t             cfg;
    timing_t          sh;
    logic             trig_wr, int_wr, busy;
    logic [SUB_W-1:0] sub;
    logic [HU_W-1:0]  hu;
    logic [LN_W-1:0]  ln;

    lcd_tg_regs u_regs (
        .clk(clk), .rst_n(rst_n), .we(reg_we), .addr(reg_addr), .wdata(reg_wdata),
        .cfg(cfg), .trig_wr(trig_wr), .int_wr(int_wr)
    );

    lcd_tg_seq #(.PIX_PER_UNIT(PIX_PER_UNIT), .HU_W(HU_W), .LN_W(LN_W)) u_seq (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .cfg(cfg),
        .trig_wr(trig_wr), .int_wr(int_wr), .busy(busy), .pwr(pwr_state),
        .sub(sub), .hu(hu), .ln(ln), .sh(sh), .frame_end(frame_end), .irq(irq)
    );

    logic [FW:0] hu_x, ln_x, h_stop, v_stop;
    logic        hs_raw, vs_raw, de_raw;

    always_comb begin
        hu_x   = (FW+1)'(hu);
        ln_x   = (FW+1)'(ln);
        h_stop = {1'b0, sh.hsp} + {1'b0, sh.hsw};
        v_stop = {1'b0, sh.vsp} + {1'b0, sh.vsw};
        hs_raw = busy && (hu_x >= {1'b0, sh.hsp}) && (hu_x < h_stop);
        vs_raw = busy && (ln_x >= {1'b0, sh.vsp}) && (ln_x < v_stop);
        de_raw = busy && (FW'(hu) < sh.hdisp) && (FW'(ln) < sh.vdisp);
        hsync  = hs_raw ^ cfg.pol_h;
        vsync  = vs_raw ^ cfg.pol_v;
        de     = de_raw ^ cfg.pol_de;
        px_x   = de_raw ? (X_W'(hu) * X_W'(PIX_PER_UNIT) + X_W'(sub)) : '0;
        px_y   = de_raw ? ln : '0;
    end

    p_idle_levels_r6: assert property (@(posedge clk) disable iff (!rst_n)
        !busy |-> (hsync == cfg.pol_h && vsync == cfg.pol_v && de == cfg.pol_de));
    p_px_blank_r12: assert property (@(posedge clk) disable iff (!rst_n)
        (de == cfg.pol_de) |-> (px_x == '0 && px_y == '0));
endmodule

// File: tb/tb_lcd_timing_gen.sv
`timescale 1ns/1ps
module tb_lcd_timing_gen;
    logic        clk = 0, rst_n = 0, dot_en = 1, reg_we = 0;
    logic [2:0]  reg_addr = 0;
    logic [31:0] reg_wdata = 0;
    logic        hsync, vsync, de, frame_end, irq;
    logic [12:0] px_x;
    logic [10:0] px_y;
    logic [1:0]  pwr_state;

    lcd_timing_gen dut (
        .clk(clk), .rst_n(rst_n), .dot_en(dot_en), .reg_we(reg_we), .reg_addr(reg_addr),
        .reg_wdata(reg_wdata), .hsync(hsync), .vsync(vsync), .de(de), .px_x(px_x),
        .px_y(px_y), .frame_end(frame_end), .irq(irq), .pwr_state(pwr_state)
    );

    always #2.5 clk = ~clk;

    int n_chk = 0, n_bad = 0;
    int fe_cnt = 0, fe_double = 0, blank_err = 0, pxmax = 0;
    logic fe_prev = 0;
    bit done = 0;

    task automatic check(input bit ok, input string tag, input longint act, input longint exp);
        n_chk++;
        if (!ok) begin
            n_bad++;
            $display("FAIL %s actual=%0d expected=%0d", tag, act, exp);
        end
    endtask

    // reference model, written from the requirements
    int m_run = 0, m_one = 0, m_pwr = 0, m_busy = 0, m_dot = 0, m_trig = 0;
    int m_fe = 0, m_stat = 0, m_fe_en = 0, m_pv = 0, m_ph = 0, m_pd = 0;
    int c_ht = 0, c_hd = 0, c_hp = 0, c_hw = 0, c_vt = 0, c_vd = 0, c_vp = 0, c_vw = 0;
    int s_ht = 0, s_hd = 0, s_hp = 0, s_hw = 0, s_vt = 0, s_vd = 0, s_vp = 0, s_vw = 0;

    always @(posedge clk) begin
        if (!rst_n) begin
            m_run = 0; m_one = 0; m_pwr = 0; m_busy = 0; m_dot = 0; m_trig = 0;
            m_fe = 0; m_stat = 0; m_fe_en = 0; m_pv = 0; m_ph = 0; m_pd = 0;
        end else begin
            int n_pwr, n_busy, n_dot, n_trig, n_fe, n_stat, go, sr;
            n_pwr = m_pwr; n_busy = m_busy; n_dot = m_dot; n_trig = m_trig;
            n_fe = 0; n_stat = m_stat; sr = 0;
            go = (!m_one || m_trig) ? 1 : 0;
            if (!m_run) begin
                n_pwr = 0; n_busy = 0; n_trig = 0; n_dot = 0;
            end else if (m_pwr == 0) begin
                n_pwr = 1;
            end else if (dot_en) begin
                if (m_pwr == 1) n_pwr = 3;
                if (m_busy) begin
                    if (m_dot == s_ht * 8 * s_vt - 1) begin
                        n_fe = 1; n_busy = 0; n_dot = 0; sr = go;
                        if (m_fe_en) n_stat = 1;
                    end else n_dot = m_dot + 1;
                end else sr = go;
                if (sr) begin
                    n_busy = 1; n_trig = 0; n_dot = 0;
                    s_ht = c_ht; s_hd = c_hd; s_hp = c_hp; s_hw = c_hw;
                    s_vt = c_vt; s_vd = c_vd; s_vp = c_vp; s_vw = c_vw;
                end
            end
            if (reg_we && reg_addr == 6 && reg_wdata[0] && m_run) n_trig = 1;
            if (reg_we && reg_addr == 7) n_stat = 0;
            if (reg_we) begin
                case (reg_addr)
                    0: begin m_run = reg_wdata[0]; m_one = reg_wdata[1]; end
                    1: begin c_hd = reg_wdata[31:16]; c_ht = reg_wdata[15:0]; end
                    2: begin c_hw = reg_wdata[31:16]; c_hp = reg_wdata[15:0]; end
                    3: begin c_vd = reg_wdata[31:16]; c_vt = reg_wdata[15:0]; end
                    4: begin c_vw = reg_wdata[31:16]; c_vp = reg_wdata[15:0]; end
                    5: begin m_pv = reg_wdata[28]; m_ph = reg_wdata[27]; m_pd = reg_wdata[24]; end
                    7: m_fe_en = reg_wdata[10];
                    default: ;
                endcase
            end
            m_pwr = n_pwr; m_busy = n_busy; m_dot = n_dot; m_trig = n_trig;
            m_fe = n_fe; m_stat = n_stat;
        end
    end

    typedef struct packed {
        logic hs, vs, de, dr;
        logic [12:0] x;
        logic [10:0] y;
        logic fe, irq;
        logic [1:0] pwr;
    } exp_t;
    exp_t sb[$];

    function automatic exp_t expect_now();
        exp_t e;
        int nh, xi, unit, line, hs, vs, dr;
        nh   = (s_ht > 0) ? s_ht * 8 : 1;
        xi   = m_dot % nh;
        unit = xi / 8;
        line = m_dot / nh;
        dr = (m_busy && unit < s_hd && line < s_vd) ? 1 : 0;
        hs = (m_busy && unit >= s_hp && unit < s_hp + s_hw) ? 1 : 0;
        vs = (m_busy && line >= s_vp && line < s_vp + s_vw) ? 1 : 0;
        e.hs  = 1'(hs ^ m_ph);
        e.vs  = 1'(vs ^ m_pv);
        e.de  = 1'(dr ^ m_pd);
        e.dr  = 1'(dr);
        e.x   = dr ? 13'(xi) : 13'd0;
        e.y   = dr ? 11'(line) : 11'd0;
        e.fe  = 1'(m_fe);
        e.irq = 1'(m_stat);
        e.pwr = 2'(m_pwr);
        return e;
    endfunction

    // driver side of the scoreboard: one expected item per rising edge
    always @(posedge clk) begin
        #1;
        if (rst_n) sb.push_back(expect_now());
    end

    // monitor side: pop and compare away from the edge
    always @(negedge clk) begin
        if (frame_end) fe_cnt++;
        if (frame_end && fe_prev) fe_double++;
        fe_prev = frame_end;
        if (int'(px_x) > pxmax) pxmax = int'(px_x);
        if (sb.size() > 0) begin
            exp_t e;
            e = sb.pop_front();
            check(hsync == e.hs, "R4/R6 hsync", hsync, e.hs);
            check(vsync == e.vs, "R5/R6 vsync", vsync, e.vs);
            check(de == e.de, "R3/R6 de", de, e.de);
            check(px_x == e.x, "R3 px_x", px_x, e.x);
            check(px_y == e.y, "R5 px_y", px_y, e.y);
            check(frame_end == e.fe, "R9 frame_end", frame_end, e.fe);
            check(irq == e.irq, "R10 irq", irq, e.irq);
            check(pwr_state == e.pwr, "R2 pwr_state", pwr_state, e.pwr);
            if (!e.dr && (px_x != 0 || px_y != 0)) blank_err++;
        end
    end

    task automatic wr(input logic [2:0] a, input logic [31:0] d);
        @(negedge clk);
        reg_we = 1; reg_addr = a; reg_wdata = d;
        @(negedge clk);
        reg_we = 0;
    endtask

    task automatic wait_fe();
        int c;
        c = fe_cnt;
        while (fe_cnt == c) @(posedge clk);
    endtask

    task automatic summary();
        $display("  test done: total=%0d bad=%0d", n_chk, n_bad);
    endtask

    initial begin
        repeat (200000) @(posedge clk);
        if (!done) begin
            n_chk++; n_bad++;
            $display("FAIL R7 watchdog actual=%0d expected=%0d", 200000, 0);
            summary();
            $finish;
        end
    end

    initial begin
        int fe0, sx, sy;
        repeat (3) @(negedge clk);
        check(hsync == 0 && vsync == 0 && de == 0, "R1 sync/de", {hsync, vsync, de}, 0);
        check(px_x == 0 && px_y == 0, "R1 pixel", px_x + px_y, 0);
        check(frame_end == 0 && irq == 0, "R1 fe/irq", {frame_end, irq}, 0);
        check(pwr_state == 0, "R1 pwr", pwr_state, 0);
        rst_n = 1;

        wr(3'd1, {16'd4, 16'd6});
        wr(3'd2, {16'd1, 16'd4});
        wr(3'd3, {16'd3, 16'd5});
        wr(3'd4, {16'd1, 16'd3});
        wr(3'd7, 32'h400);
        wr(3'd0, 32'h1);
        fe0 = fe_cnt;
        check(pwr_state == 0, "R2 after write", pwr_state, 0);
        @(negedge clk); check(pwr_state == 1, "R2 rising", pwr_state, 1);
        @(negedge clk); check(pwr_state == 3, "R2 on", pwr_state, 3);
        repeat (600) @(negedge clk);
        check(fe_cnt - fe0 == 2, "R7 back-to-back frames", fe_cnt - fe0, 2);
        check(irq == 1, "R10 status set", irq, 1);
        wr(3'd7, 32'h400);
        check(irq == 0, "R10 cleared by write", irq, 0);

        wr(3'd5, (32'd1 << 28) | (32'd1 << 27) | (32'd1 << 24));
        repeat (300) @(negedge clk);

        wait_fe();
        repeat (20) @(negedge clk);
        wr(3'd1, {16'd5, 16'd8});
        pxmax = 0;
        wait_fe();
        check(pxmax == 31, "R11 old width kept", pxmax, 31);
        @(negedge clk);
        pxmax = 0;
        repeat (330) @(negedge clk);
        check(pxmax == 39, "R11 new width used", pxmax, 39);

        @(negedge clk);
        dot_en = 0;
        @(negedge clk);
        sx = int'(px_x); sy = int'(px_y);
        repeat (5) @(negedge clk);
        check(int'(px_x) == sx && int'(px_y) == sy, "R13 hold", px_x, sx);
        dot_en = 1;
        for (int i = 0; i < 300; i++) begin
            @(negedge clk);
            dot_en = (i % 3 != 0);
        end
        @(negedge clk);
        dot_en = 1;

        wr(3'd0, 32'h0);
        check(pwr_state == 3, "R2 one edge late", pwr_state, 3);
        @(negedge clk);
        check(pwr_state == 0, "R2 off", pwr_state, 0);
        check(hsync == 1 && vsync == 1 && de == 1, "R6 idle levels", {hsync, vsync, de}, 7);
        wr(3'd5, 32'h0);

        wr(3'd0, 32'h3);
        repeat (300) @(negedge clk);
        fe0 = fe_cnt;
        check(pwr_state == 3, "R8 powered idle", pwr_state, 3);
        repeat (300) @(negedge clk);
        check(fe_cnt == fe0, "R8 no frame without trigger", fe_cnt - fe0, 0);
        wr(3'd6, 32'h0);
        repeat (300) @(negedge clk);
        check(fe_cnt == fe0, "R8 zero trigger ignored", fe_cnt - fe0, 0);
        wr(3'd6, 32'h1);
        repeat (400) @(negedge clk);
        check(fe_cnt == fe0 + 1, "R8 one frame", fe_cnt - fe0, 1);
        repeat (400) @(negedge clk);
        check(fe_cnt == fe0 + 1, "R8 stays idle", fe_cnt - fe0, 1);

        check(blank_err == 0, "R12 blank pixels", blank_err, 0);
        check(fe_double == 0, "R9 single pulse", fe_double, 0);
        done = 1;
        summary();
        $finish;
    end
endmodule